// File: doc/BRIEF.md
# Six-Channel Shared-Counter PWM Bank

This block drives six pins with pulse-width-modulated waveforms. All six share one 8-bit free-running step counter, so a frame is 256 steps long. The counter advances on a prescaler tick input, one step per tick. Each channel compares the counter with its own 8-bit duty value. A channel's pin is driven high while the count is at or below that value. The high time is therefore one step longer than the value written, which means zero duty cannot be produced and a value of 255 gives a pin that is high for the whole frame.

Register access is reduced to plain write strobes. Each channel has a duty strobe that shares one data bus. A single control strobe loads three things at once: the six channel enables, one polarity bit common to all channels, and one counter-halt bit. A duty write first lands in a holding register and reaches the comparator only when the counter wraps to zero, so a frame is never cut short or stretched by a write. A channel that is not enabled passes its general-purpose output bit straight through to the pin.

Top module: `pwm_bank`

## Requirements
- R1: While the halt bit is 0, each clock with `step_tick` high advances the shared counter by one, and it wraps from 255 to 0, so a frame is 256 steps.
- R2: With polarity 0 and the channel enabled, the pin is 1 while the counter is in 0..D and 0 for the rest of the frame, where D is the channel's active duty value. The pin is therefore high for D+1 of 256 steps, is always high at count 0, and is high for the whole frame when D is 255.
- R3: With polarity 1, every enabled pin is the inverse of its R2 level.
- R4: A duty write is held and becomes the active value only at the edge where the counter wraps from 255 to 0. A write made in the same cycle as a wrap applies at the following wrap.
- R5: A pin whose enable bit is 0 equals its `gpio_out` bit in the same cycle, whatever the counter or duty.
- R6: While the halt bit is 1 the counter does not move, even when ticks arrive, and every enabled pin keeps its level.
- R7: After reset the enables, polarity and halt bit are 0, the counter is 0, and every duty value (held and active) is 0.
- R8: In a clock without `step_tick` the counter does not move and the enabled pins do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_tick | input | 1 | Prescaler pulse; one counter step per high clock |
| duty_wr | input | 6 | Per-channel duty write strobes |
| duty_wdata | input | 8 | Duty value written by any strobe |
| ctrl_wr | input | 1 | Loads enables, polarity and halt bit |
| ctrl_en_wdata | input | 6 | New channel enable bits (1 = PWM on pin) |
| ctrl_pol_wdata | input | 1 | New polarity (1 = inverted) |
| ctrl_halt_wdata | input | 1 | New halt bit (1 = counter frozen) |
| gpio_out | input | 6 | Pin values used by disabled channels |
| pwm_pin | output | 6 | Pin outputs |

## Verification
The hardest case to reach is a duty write landing in the very cycle the counter wraps, which must apply one frame later rather than at once. The bench reaches it by using its own step count to find the step where the count is 255, and issuing the strobe together with the tick that causes the wrap. The bench also sweeps every duty value 0..255 on channel 0, with the other five channels offset. In that sweep the writes fall at a point in mid-frame that shifts from frame to frame, so the deferral is checked at many counter positions.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  // Raw (non-inverted) channel level: high for counts 0..duty inclusive.
  function automatic logic raw_level(input logic [15:0] count, input logic [15:0] duty);
    return count <= duty;
  endfunction
endpackage

// File: rtl/pwm_step_counter.sv
module pwm_step_counter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          halt,
  output logic [DW-1:0] count,
  output logic          advance,
  output logic          wrap
);
  localparam logic [DW-1:0] LAST = {DW{1'b1}};

  assign advance = tick & ~halt;
  assign wrap    = advance & (count == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (advance) count <= count + 1'b1;
  end
endmodule

// File: rtl/pwm_ctrl_reg.sv
module pwm_ctrl_reg #(
  parameter int NCH = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr,
  input  logic [NCH-1:0] en_d,
  input  logic           pol_d,
  input  logic           halt_d,
  output logic [NCH-1:0] en_q,
  output logic           pol_q,
  output logic           halt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= 1'b0;
      halt_q <= 1'b0;
    end else if (wr) begin
      en_q   <= en_d;
      pol_q  <= pol_d;
      halt_q <= halt_d;
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_bank_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          wrap,
  input  logic [DW-1:0] count,
  input  logic          pol,
  input  logic          en,
  input  logic          gpio,
  output logic          pin,
  output logic [DW-1:0] active
);
  logic [DW-1:0] held;
  logic          level;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held   <= '0;
      active <= '0;
    end else begin
      if (wr)   held   <= wdata;
      if (wrap) active <= held;
    end
  end

  assign level = raw_level(16'(count), 16'(active)) ^ pol;
  assign pin   = en ? level : gpio;
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
  parameter int NCH = 6,
  parameter int DW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step_tick,
  input  logic [NCH-1:0] duty_wr,
  input  logic [DW-1:0]  duty_wdata,
  input  logic           ctrl_wr,
  input  logic [NCH-1:0] ctrl_en_wdata,
  input  logic           ctrl_pol_wdata,
  input  logic           ctrl_halt_wdata,
  input  logic [NCH-1:0] gpio_out,
  output logic [NCH-1:0] pwm_pin
);
  logic [DW-1:0]     count;
  logic              advance;
  logic              wrap;
  logic [NCH-1:0]    chan_en;
  logic              pol;
  logic              halt;
  logic [NCH*DW-1:0] active_flat;

  pwm_ctrl_reg #(.NCH(NCH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr(ctrl_wr),
    .en_d(ctrl_en_wdata), .pol_d(ctrl_pol_wdata), .halt_d(ctrl_halt_wdata),
    .en_q(chan_en), .pol_q(pol), .halt_q(halt)
  );

  pwm_step_counter #(.DW(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(step_tick), .halt(halt),
    .count(count), .advance(advance), .wrap(wrap)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    pwm_chan #(.DW(DW)) u_chan (
      .clk(clk), .rst_n(rst_n), .wr(duty_wr[g]), .wdata(duty_wdata),
      .wrap(wrap), .count(count), .pol(pol), .en(chan_en[g]),
      .gpio(gpio_out[g]), .pin(pwm_pin[g]),
      .active(active_flat[g*DW +: DW])
    );
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NCH = 6,
  parameter int DW  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              step_tick,
  input logic              ctrl_wr,
  input logic [NCH-1:0]    gpio_out,
  input logic [NCH-1:0]    pwm_pin,
  input logic [DW-1:0]     count,
  input logic              advance,
  input logic              wrap,
  input logic [NCH-1:0]    chan_en,
  input logic              pol,
  input logic              halt,
  input logic [NCH*DW-1:0] active_flat
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_tick && !halt) |=> (count == $past(count) + ONE));

  // R8
  count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_tick |=> $stable(count));

  // R4
  active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(active_flat));

  // R5
  gpio_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pwm_pin & ~chan_en) == (gpio_out & ~chan_en)));

  // R2
  frame_start_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !pol) |-> ((pwm_pin & chan_en) == chan_en));

  // R3
  frame_start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && pol) |-> ((pwm_pin & chan_en) == '0));

  // R6
  halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !ctrl_wr) |=> ($stable(count) && $stable(pwm_pin & chan_en)));
endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_tick(step_tick), .ctrl_wr(ctrl_wr),
  .gpio_out(gpio_out), .pwm_pin(pwm_pin), .count(count), .advance(advance),
  .wrap(wrap), .chan_en(chan_en), .pol(pol), .halt(halt),
  .active_flat(active_flat)
);

// File: tb/tb_pwm_bank.sv
`timescale 1ns/1ps
module tb_pwm_bank;
  localparam int NCH = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           step_tick = 1'b0;
  logic [NCH-1:0] duty_wr = '0;
  logic [7:0]     duty_wdata = '0;
  logic           ctrl_wr = 1'b0;
  logic [NCH-1:0] ctrl_en_wdata = '0;
  logic           ctrl_pol_wdata = 1'b0;
  logic           ctrl_halt_wdata = 1'b0;
  logic [NCH-1:0] gpio_out = '0;
  logic [NCH-1:0] pwm_pin;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Bench model state, derived from the requirements.
  int m_cnt = 0;
  int m_held [NCH];
  int m_act  [NCH];
  logic [NCH-1:0] m_en = '0;
  logic m_pol = 1'b0;
  logic m_halt = 1'b0;

  always #5 clk = ~clk;

  pwm_bank dut (
    .clk(clk), .rst_n(rst_n), .step_tick(step_tick), .duty_wr(duty_wr),
    .duty_wdata(duty_wdata), .ctrl_wr(ctrl_wr), .ctrl_en_wdata(ctrl_en_wdata),
    .ctrl_pol_wdata(ctrl_pol_wdata), .ctrl_halt_wdata(ctrl_halt_wdata),
    .gpio_out(gpio_out), .pwm_pin(pwm_pin)
  );

  function automatic logic [NCH-1:0] expect_pins();
    logic [NCH-1:0] e;
    for (int c = 0; c < NCH; c++) begin
      logic lv;
      lv = (m_cnt <= m_act[c]) ? 1'b1 : 1'b0;
      e[c] = m_en[c] ? (lv ^ m_pol) : gpio_out[c];
    end
    return e;
  endfunction

  task automatic check(input string req);
    logic [NCH-1:0] e;
    e = expect_pins();
    checks++;
    if (pwm_pin !== e) begin
      failures++;
      $display("FAIL %s cnt=%0d actual=%b expected=%b", req, m_cnt, pwm_pin, e);
    end
  endtask

  // One clock with the currently driven inputs; strobes cleared afterwards.
  task automatic cyc(input logic tick, input string req);
    step_tick = tick;
    @(posedge clk);
    if (tick && !m_halt) begin
      if (m_cnt == 255) for (int c = 0; c < NCH; c++) m_act[c] = m_held[c];
      m_cnt = (m_cnt + 1) % 256;
    end
    for (int c = 0; c < NCH; c++) if (duty_wr[c]) m_held[c] = duty_wdata;
    if (ctrl_wr) begin
      m_en = ctrl_en_wdata; m_pol = ctrl_pol_wdata; m_halt = ctrl_halt_wdata;
    end
    @(negedge clk);
    duty_wr = '0; ctrl_wr = 1'b0; step_tick = 1'b0;
    check(req);
  endtask

  task automatic set_ctrl(input logic [NCH-1:0] en, input logic pol, input logic halt);
    ctrl_wr = 1'b1; ctrl_en_wdata = en; ctrl_pol_wdata = pol; ctrl_halt_wdata = halt;
  endtask

  initial begin
    #1_900_000;
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin m_held[c] = 0; m_act[c] = 0; end
    gpio_out = 6'h2A;
    repeat (3) @(negedge clk);
    check("R7 reset gpio passthrough");
    rst_n = 1'b1;
    @(negedge clk);
    check("R7 after release");

    // R7: enable all without writing duty; reset duty 0 gives one high step.
    set_ctrl('1, 1'b0, 1'b0);
    for (int i = 0; i < 260; i++) cyc(1'b1, "R7 reset duty zero");

    // R2 / R4: sweep every duty value, writes land mid-frame.
    for (int d = 0; d < 256; d++) begin
      for (int c = 0; c < NCH; c++) begin
        duty_wr = '0; duty_wr[c] = 1'b1;
        duty_wdata = 8'((d + c * 43) % 256);
        cyc(1'b1, "R4 mid-frame write");
      end
      for (int i = 0; i < 250 + (d % 7); i++) cyc(1'b1, "R2 duty sweep");
    end

    // R3: inverted polarity for two frames.
    set_ctrl('1, 1'b1, 1'b0);
    for (int i = 0; i < 520; i++) cyc(1'b1, "R3 polarity");

    // R8: sparse ticks.
    set_ctrl('1, 1'b0, 1'b0);
    for (int i = 0; i < 800; i++) cyc((i % 3) == 0, "R8 tick gating");

    // R6: halt with ticks arriving, at varied counts.
    for (int k = 0; k < 4; k++) begin
      logic [NCH-1:0] snap;
      for (int i = 0; i < 37 + k * 50; i++) cyc(1'b1, "R1 run");
      set_ctrl('1, 1'b0, 1'b1);
      cyc(1'b1, "R6 halt write");
      snap = pwm_pin;
      for (int i = 0; i < 300; i++) cyc(1'b1, "R6 halted");
      checks++;
      if (pwm_pin !== snap) begin
        failures++;
        $display("FAIL R6 hold actual=%b expected=%b", pwm_pin, snap);
      end
      set_ctrl('1, 1'b0, 1'b0);
      cyc(1'b0, "R6 release");
    end

    // R4: write in the very cycle of the wrap.
    while (m_cnt != 255) cyc(1'b1, "R1 approach wrap");
    duty_wr = '1; duty_wdata = 8'd200;
    cyc(1'b1, "R4 write at wrap");
    for (int i = 0; i < 520; i++) cyc(1'b1, "R4 deferred write");

    // R5: partial enable with every gpio pattern.
    set_ctrl(6'b101010, 1'b0, 1'b0);
    for (int i = 0; i < 512; i++) begin
      gpio_out = 6'(i);
      cyc(1'b1, "R5 disabled gpio");
    end

    // R1: full frames, all enabled, boundary duty values.
    set_ctrl('1, 1'b0, 1'b0);
    duty_wr = 6'b000011; duty_wdata = 8'd255; cyc(1'b1, "R2 write 255");
    duty_wr = 6'b001100; duty_wdata = 8'd0;   cyc(1'b1, "R2 write 0");
    for (int i = 0; i < 600; i++) cyc(1'b1, "R1 frame length");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule